// File: doc/BRIEF.md
# Set-Associative Cache Controller with Runtime Policies

The block is a word-wide cache placed between a processor and a block-wide backing memory. The way count (1 to 5, not only powers of two), the set count (a power of two from 1 to 16) and the block size (4 to 32 bytes) are fixed when the design is elaborated. Two configuration inputs can be changed between requests. One picks the replacement policy: least-recently-used, or pseudo-random. The other picks the write policy: write-back, or write-through.

Every way keeps a valid flag, a dirty flag, an LRU rank, a tag and a data block. The tag is right-aligned, so the bits above the tag width are zero. Addresses are 32-bit byte addresses. The offset is the low log2(block bytes) bits, the index is the next log2(sets) bits, and the tag is the rest. The processor sends one request at a time with a valid/ready handshake. The controller answers with a one-cycle response pulse, which carries the read word, a hit flag, and the set and way that served the access.

On a miss the controller chooses a victim way. If that victim holds dirty data, the controller first writes the whole victim block to memory. It then refills the way from memory with a full-block read. Every memory transfer moves exactly one whole block.

Top module: `cache_ctrl`

## Requirements
- R1: Reset, and a one-cycle `flush`, leave every way invalid and clean. LRU ranks return to rank = way number. Flush starts no memory transfer and discards dirty data without writing it back, so the next access to any address misses.
- R2: A read hit raises `rsp_valid` in the cycle after the request is accepted, with `rsp_hit`=1 and the stored word, and starts no memory transfer.
- R3: A read miss performs one block read at byte address {tag, index, zeros}. Word o of a block sits at bits [32*o+31:32*o] of the memory data buses. The response has `rsp_hit`=0 and the requested word, and the way is installed clean.
- R4: Under write-back (`cfg_wthru`=0), a store hit updates the word, sets the way dirty and starts no memory transfer. A miss whose victim is valid and dirty first writes the victim's full block to its own block address and then reads the new block. A clean victim is never written.
- R5: Under write-through (`cfg_wthru`=1), every store, hit or miss, sends one full-block write of the updated block to its block address. On a miss this write follows the refill read.
- R6: When the addressed set holds an invalid way, a miss fills the lowest-numbered invalid way, whatever the replacement policy.
- R7: Under LRU (`cfg_random`=0), with every way of the set valid, the victim is the way touched least recently. Hits and fills both count as touches. Exactly one way per set holds the oldest rank at all times.
- R8: Under random replacement (`cfg_random`=1), with every way of the set valid, the victim is a free-running 16-bit LFSR value modulo the way count, so it is always a legal way number.
- R9: `mem_req` stays high, with a stable address and direction, until `mem_ack` is seen. Only one memory transfer is outstanding at a time.
- R10: `cpu_ready` is high only while the controller is idle and `flush` is low. `rsp_set` equals the index bits of the request, and `rsp_way` is the way that hit or was filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all ways for one cycle |
| cfg_random | input | 1 | 1 = random replacement, 0 = LRU |
| cfg_wthru | input | 1 | 1 = write-through, 0 = write-back |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Controller accepts a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_rdata | output | 32 | Loaded word |
| rsp_set | output | SET_W | Set used by the request |
| rsp_way | output | WAY_W | Way hit or filled |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | BLK_W | Block written to memory |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | BLK_W | Block read from memory |

## Verification
Two things can happen on the same clock edge: the refill that installs a block from memory, and the merge of a pending store word into that block. On that edge the tag, the valid flag, the LRU rank and the dirty flag (under write-back) must all be set together. Long mixed runs of loads and stores provoke this with many store misses, some of them evicting dirty victims under write-back and others issuing a block write under write-through. The result is judged against the bench's own memory image, in three places: the block carried by each write-through transfer, the block later carried out by the eviction of that way, and every subsequent load of the stored word.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_WTHRU
    } cst_e;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = {1'b0, val_q[W-1:1]} ^ (val_q[0] ? TAPS : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= W'(1);
        else        val_q <= val_d;
    end

    assign value = val_q;

    // R8: the generator never locks up in the all-zero state
    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        val_q != '0);
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
    parameter int WAYS  = 3,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    input  logic [15:0]                rnd,
    input  logic                       use_rnd,
    output logic [WAY_W-1:0]           way
);
    logic             inv_found;
    logic [WAY_W-1:0] inv_way, old_way, rnd_way;

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        old_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
            if (age[w] == AGE_W'(WAYS - 1)) old_way = WAY_W'(w);
        end
        rnd_way = WAY_W'(32'(rnd) % WAYS);
        way     = inv_found ? inv_way : (use_rnd ? rnd_way : old_way);
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl import cache_pkg::*; #(
    parameter  int WAYS        = 3,
    parameter  int SETS        = 4,
    parameter  int BLOCK_BYTES = 16,
    localparam int IDX_W       = $clog2(SETS),
    localparam int SET_W       = (IDX_W > 0) ? IDX_W : 1,
    localparam int WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int BLK_W       = BLOCK_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             cfg_random,
    input  logic             cfg_wthru,
    input  logic             cpu_valid,
    output logic             cpu_ready,
    input  logic             cpu_we,
    input  logic [31:0]      cpu_addr,
    input  logic [31:0]      cpu_wdata,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [31:0]      rsp_rdata,
    output logic [SET_W-1:0] rsp_set,
    output logic [WAY_W-1:0] rsp_way,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [BLK_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [BLK_W-1:0] mem_rdata
);
    localparam int WORDS   = BLOCK_BYTES / 4;
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int WOFF_W  = $clog2(WORDS);
    localparam int WOFF_WS = (WOFF_W > 0) ? WOFF_W : 1;
    localparam int TAG_W   = 32 - OFF_W - IDX_W;
    localparam int AGE_W   = WAY_W;

    typedef logic [WAYS-1:0][AGE_W-1:0] rank_t;

    typedef struct packed {
        cst_e                                  st;
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0]             drt;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][BLK_W-1:0]  data;
        logic                                  r_we;
        logic                                  r_hit;
        logic [TAG_W-1:0]                      r_tag;
        logic [SET_W-1:0]                      r_set;
        logic [WOFF_WS-1:0]                    r_woff;
        logic [WAY_W-1:0]                      r_way;
        logic [31:0]                           r_wdata;
        logic                                  rsp_v;
        logic [31:0]                           rsp_data;
    } state_t;

    state_t s_d, s_q;

    function automatic state_t fresh();
        state_t r;
        r = '0;
        for (int st = 0; st < SETS; st++)
            for (int w = 0; w < WAYS; w++)
                r.age[st][w] = AGE_W'(w);
        r.st = ST_IDLE;
        return r;
    endfunction

    // touched way becomes rank 0, younger ways age by one
    function automatic rank_t touched(input rank_t a, input logic [WAY_W-1:0] tw);
        rank_t r;
        for (int v = 0; v < WAYS; v++) begin
            if (v == int'(tw))      r[v] = '0;
            else if (a[v] < a[tw])  r[v] = a[v] + 1'b1;
            else                    r[v] = a[v];
        end
        return r;
    endfunction

    function automatic logic [31:0] blk_addr(input logic [TAG_W-1:0] t,
                                             input logic [SET_W-1:0] ix);
        logic [31:0] a;
        a = '0;
        a[OFF_W+IDX_W +: TAG_W] = t;
        if (SETS > 1) a[OFF_W +: SET_W] = ix;
        return a;
    endfunction

    // request address split
    logic [TAG_W-1:0]   c_tag;
    logic [SET_W-1:0]   c_set;
    logic [WOFF_WS-1:0] c_woff;
    logic               unused_addr_bits;

    assign c_tag  = cpu_addr[OFF_W+IDX_W +: TAG_W];
    assign c_set  = (SETS > 1)  ? cpu_addr[OFF_W +: SET_W] : '0;
    assign c_woff = (WORDS > 1) ? cpu_addr[2 +: WOFF_WS]   : '0;
    assign unused_addr_bits = ^cpu_addr[1:0];

    // lookup
    logic             hit;
    logic [WAY_W-1:0] hit_way;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (s_q.vld[c_set][w] && s_q.tag[c_set][w] == c_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    logic [15:0]      rnd;
    logic [WAY_W-1:0] vic_way;

    cache_lfsr #(.W(16), .TAPS(16'hB400)) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    cache_victim #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) i_victim (
        .vld     (s_q.vld[c_set]),
        .age     (s_q.age[c_set]),
        .rnd     (rnd),
        .use_rnd (cfg_random),
        .way     (vic_way)
    );

    always_comb begin
        logic [BLK_W-1:0] blk;
        state_t           clr;
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        blk       = '0;
        clr       = fresh();
        unique case (s_q.st)
            ST_IDLE: if (cpu_valid) begin
                s_d.r_we    = cpu_we;
                s_d.r_wdata = cpu_wdata;
                s_d.r_tag   = c_tag;
                s_d.r_set   = c_set;
                s_d.r_woff  = c_woff;
                s_d.r_hit   = hit;
                if (hit) begin
                    s_d.r_way      = hit_way;
                    s_d.age[c_set] = touched(s_q.age[c_set], hit_way);
                    blk            = s_q.data[c_set][hit_way];
                    if (cpu_we) begin
                        blk[32*int'(c_woff) +: 32]  = cpu_wdata;
                        s_d.data[c_set][hit_way]    = blk;
                        if (cfg_wthru) begin
                            s_d.st = ST_WTHRU;
                        end else begin
                            s_d.drt[c_set][hit_way] = 1'b1;
                            s_d.rsp_v               = 1'b1;
                        end
                    end else begin
                        s_d.rsp_data = blk[32*int'(c_woff) +: 32];
                        s_d.rsp_v    = 1'b1;
                    end
                end else begin
                    s_d.r_way = vic_way;
                    s_d.st    = (s_q.vld[c_set][vic_way] && s_q.drt[c_set][vic_way])
                                ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: if (mem_ack) s_d.st = ST_FILL;
            ST_FILL: if (mem_ack) begin
                blk          = mem_rdata;
                s_d.rsp_data = mem_rdata[32*int'(s_q.r_woff) +: 32];
                if (s_q.r_we) blk[32*int'(s_q.r_woff) +: 32] = s_q.r_wdata;
                s_d.data[s_q.r_set][s_q.r_way] = blk;
                s_d.tag[s_q.r_set][s_q.r_way]  = s_q.r_tag;
                s_d.vld[s_q.r_set][s_q.r_way]  = 1'b1;
                s_d.drt[s_q.r_set][s_q.r_way]  = s_q.r_we && !cfg_wthru;
                s_d.age[s_q.r_set] = touched(s_q.age[s_q.r_set], s_q.r_way);
                if (s_q.r_we && cfg_wthru) begin
                    s_d.st = ST_WTHRU;
                end else begin
                    s_d.st    = ST_IDLE;
                    s_d.rsp_v = 1'b1;
                end
            end
            ST_WTHRU: if (mem_ack) begin
                s_d.st    = ST_IDLE;
                s_d.rsp_v = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (flush) begin
            s_d.vld   = '0;
            s_d.drt   = '0;
            s_d.age   = clr.age;
            s_d.st    = ST_IDLE;
            s_d.rsp_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= fresh();
        else        s_q <= s_d;
    end

    assign cpu_ready = (s_q.st == ST_IDLE) && !flush;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_hit   = s_q.r_hit;
    assign rsp_rdata = s_q.rsp_data;
    assign rsp_set   = s_q.r_set;
    assign rsp_way   = s_q.r_way;
    assign mem_req   = (s_q.st != ST_IDLE);
    assign mem_we    = (s_q.st == ST_WBACK) || (s_q.st == ST_WTHRU);
    assign mem_addr  = blk_addr((s_q.st == ST_WBACK) ? s_q.tag[s_q.r_set][s_q.r_way]
                                                      : s_q.r_tag, s_q.r_set);
    assign mem_wdata = s_q.data[s_q.r_set][s_q.r_way];

    // ---------------- assertions ----------------
    assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.vld == '0) && (s_q.drt == '0) && !mem_req);

    assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && hit && !cpu_we) |=> (rsp_valid && rsp_hit && !mem_req));

    assert_dirty_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.drt & ~s_q.vld) == '0);

    assert_victim_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILL) |-> (int'(s_q.r_way) < WAYS));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !flush) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    for (genvar gs = 0; gs < SETS; gs++) begin : g_rank
        logic [WAYS-1:0] oldest;
        always_comb begin
            for (int w = 0; w < WAYS; w++)
                oldest[w] = (s_q.age[gs][w] == AGE_W'(WAYS - 1));
        end
        assert_lru_rank_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest) == 1);
    end
endmodule

// File: tb/test_cache_ctrl.sv
`timescale 1ns/1ps
module test_cache_ctrl;
    localparam int WAYS = 3, SETS = 4, BB = 16, BLK_W = BB * 8;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, cfg_random = 1'b0, cfg_wthru = 1'b0;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic cpu_ready, rsp_valid, rsp_hit, mem_req, mem_we;
    logic [31:0] rsp_rdata, mem_addr;
    logic [1:0] rsp_set, rsp_way;
    logic [BLK_W-1:0] mem_wdata, mem_rdata;
    logic mem_ack;

    always #2 clk = ~clk;

    cache_ctrl #(.WAYS(WAYS), .SETS(SETS), .BLOCK_BYTES(BB)) i_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_random(cfg_random), .cfg_wthru(cfg_wthru),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .rsp_set(rsp_set), .rsp_way(rsp_way), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] bmem [256];
    logic [31:0] refmem [256];
    bit rv [SETS][WAYS], rd [SETS][WAYS];
    int rt [SETS][WAYS], ra [SETS][WAYS];
    int n_ops;
    logic op_we [8];
    logic [31:0] op_addr [8];
    logic [BLK_W-1:0] op_data [8];
    logic got_hit;
    logic [1:0] got_way, got_set;
    logic [31:0] got_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // backing memory: acks every request on its second observed cycle
    initial begin
        bit wait_c;
        wait_c  = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_c) begin
                    int b;
                    wait_c = 0;
                    b = int'(mem_addr[9:2]);
                    if (mem_we) for (int i = 0; i < 4; i++) bmem[b + i] = mem_wdata[32*i +: 32];
                    else        for (int i = 0; i < 4; i++) mem_rdata[32*i +: 32] = bmem[b + i];
                    if (n_ops < 8) begin
                        op_we[n_ops]   = mem_we;
                        op_addr[n_ops] = mem_addr;
                        op_data[n_ops] = mem_we ? mem_wdata : '0;
                    end
                    n_ops++;
                    mem_ack = 1'b1;
                end else begin
                    wait_c = 1;
                end
            end
        end
    end

    function automatic logic [BLK_W-1:0] refblk(input int byte_addr);
        logic [BLK_W-1:0] r;
        for (int i = 0; i < 4; i++) r[32*i +: 32] = refmem[(byte_addr >> 2) + i];
        return r;
    endfunction

    task automatic ref_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                rv[s][w] = 0; rd[s][w] = 0; rt[s][w] = 0; ra[s][w] = w;
            end
    endtask

    task automatic ref_touch(input int s, input int v);
        int pivot;
        pivot = ra[s][v];
        for (int w = 0; w < WAYS; w++)
            if (w == v) ra[s][w] = 0;
            else if (ra[s][w] < pivot) ra[s][w]++;
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd);
        int guard;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        n_ops = 0;
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
        chk(rsp_valid, "R10", "response arrives", {127'b0, rsp_valid}, 1);
        got_hit = rsp_hit; got_way = rsp_way; got_set = rsp_set; got_data = rsp_rdata;
    endtask

    task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] wd);
        int s, tg, wi, hw, inv, old, v, k, exp_ops, vaddr, baddr;
        bit wb;
        s = int'(a[5:4]); tg = int'(a[9:6]); wi = int'(a[9:2]);
        baddr = int'(a) & ~15;
        hw = -1; inv = -1; old = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (rv[s][w] && rt[s][w] == tg) hw = w;
            if (!rv[s][w]) inv = w;
            if (ra[s][w] == WAYS - 1) old = w;
        end
        access(we, a, wd);
        chk(int'(got_set) == s, "R10", "reported set", got_set, s);
        if (hw >= 0) begin
            chk(got_hit == 1'b1, "R2", "hit flag", got_hit, 1);
            chk(int'(got_way) == hw, "R10", "hit way", got_way, hw);
            v = hw;
        end else begin
            chk(got_hit == 1'b0, "R3", "miss flag", got_hit, 0);
            if (inv >= 0) begin
                chk(int'(got_way) == inv, "R6", "invalid way first", got_way, inv); v = inv;
            end else if (!cfg_random) begin
                chk(int'(got_way) == old, "R7", "LRU victim", got_way, old); v = old;
            end else begin
                chk(int'(got_way) < WAYS, "R8", "random victim range", got_way, WAYS - 1);
                v = (int'(got_way) < WAYS) ? int'(got_way) : 0;
            end
        end
        if (!we) chk(got_data == refmem[wi], hw >= 0 ? "R2" : "R3", "load data", got_data, refmem[wi]);
        wb = (hw < 0) && rv[s][v] && rd[s][v];
        vaddr = rt[s][v] * 64 + s * 16;
        if (hw < 0) begin rv[s][v] = 1; rt[s][v] = tg; rd[s][v] = 0; end
        ref_touch(s, v);
        if (we) begin
            refmem[wi] = wd;
            if (!cfg_wthru) rd[s][v] = 1;
        end
        exp_ops = int'(wb) + int'(hw < 0) + int'(we && cfg_wthru);
        chk(n_ops == exp_ops, cfg_wthru ? "R5" : "R4", "memory transfer count", n_ops, exp_ops);
        if (n_ops == exp_ops) begin
            k = 0;
            if (wb) begin
                chk(op_we[0] && op_addr[0] == vaddr && op_data[0] == refblk(vaddr),
                    "R4", "dirty victim written first", op_data[0], refblk(vaddr));
                k++;
            end
            if (hw < 0) begin
                chk(!op_we[k] && op_addr[k] == baddr, "R3", "block read address", op_addr[k], baddr);
                k++;
            end
            if (we && cfg_wthru)
                chk(op_we[k] && op_addr[k] == baddr && op_data[k] == refblk(baddr),
                    "R5", "write-through block", op_data[k], refblk(baddr));
        end
    endtask

    task automatic mixed(input int count, input logic [31:0] seed);
        logic [31:0] x, a;
        x = seed;
        for (int i = 0; i < count; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            if (x[3:0] < 4'd9) a = ((x >> 8) % 32'd192) & ~32'd3;
            else               a = (x >> 8) & 32'h3FC;
            do_op(x[30:29] == 2'b00, a, x ^ 32'(i));
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        n_ops = 0;
        flush = 1'b1;
        #1 chk(!cpu_ready, "R10", "ready low during flush", cpu_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        chk(n_ops == 0, "R1", "flush starts no transfer", n_ops, 0);
        ref_reset();
        for (int i = 0; i < 256; i++) refmem[i] = bmem[i];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 32'hA5000000 ^ (32'(i) * 32'h01030507);
            refmem[i] = bmem[i];
        end
        ref_reset();
        n_ops = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready && !rsp_valid && !mem_req, "R1", "idle after reset",
            {cpu_ready, rsp_valid, mem_req}, 3'b100);

        // directed sweep: fill every way, then force LRU evictions
        for (int t = 0; t < 5; t++)
            for (int s = 0; s < SETS; s++)
                do_op(1'b0, 32'(t * 64 + s * 16 + (t % 4) * 4), '0);
        for (int t = 2; t < 5; t++) do_op(1'b0, 32'(t * 64 + 4), '0);

        mixed(400, 32'h1234);                       // LRU, write-back
        cfg_wthru = 1'b1;  mixed(400, 32'hBEEF);     // LRU, write-through
        cfg_wthru = 1'b0; cfg_random = 1'b1;
        mixed(400, 32'h7777);                       // random, write-back
        cfg_random = 1'b0;
        do_flush();                                 // discards dirty lines (R1)
        for (int s = 0; s < SETS; s++) do_op(1'b0, 32'(s * 16), '0);
        mixed(200, 32'h4242);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule